// File: doc/BRIEF.md
# Reconfigurable Column Data Loader

This block loads one line of binary pixel values for a bank of 96 display columns. Pixel bits arrive on a parallel bus of up to six lines. On every rising clock edge they enter a single 96-bit register, which can be organised as six interleaved lanes of 16 stages or three interleaved lanes of 32 stages. A direction input chooses whether new bits enter at the low-numbered columns and travel upward, or enter at the high-numbered columns and travel downward.

A hold-controlled latch stands between the register and the column outputs. While the hold input is low, the latch copies the register on each rising edge. While it is high, the latch keeps its contents, so the next line can be loaded while the current one is displayed. Two override inputs come last. One blanks every column low. The other forces every column high. With neither asserted, each column shows its latched bit.

Shift behaviour is chosen by a decoded mode with four states: `SM_WIDE_FWD`, `SM_WIDE_REV`, `SM_NARROW_FWD` and `SM_NARROW_REV`. The two pins are decoded again on every edge, so changing mode or direction is a change of state. It takes effect at the next rising edge, and any transition between the four states is allowed. The column drive is decoded into `DRV_LOW`, `DRV_HIGH` or `DRV_DATA`. Here blanking has priority over forcing high, and forcing high has priority over data.

Top module: `col_loader`

## Requirements
- R1: An asynchronous active-low reset clears both the shift register and the latch, so with both overrides inactive all 96 columns read 0.
- R2: With `lane_sel`=0 and `dir_rev`=0, `din[k-1]` sampled at an edge enters column k (k=1..6) and moves up six columns per edge, reaching column 90+k after 16 edges.
- R3: With `lane_sel`=0 and `dir_rev`=1, `din[k-1]` enters column 90+k and moves down six columns per edge, reaching column k after 16 edges.
- R4: With `lane_sel`=1 and `dir_rev`=0, `din[k-1]` (k=1..3) enters column k and moves up three columns per edge, reaching column 93+k after 32 edges.
- R5: With `lane_sel`=1 and `dir_rev`=1, `din[k-1]` (k=1..3) enters column 93+k and moves down three columns per edge, reaching column k after 32 edges.
- R6: With `lane_sel`=1, `din[5:3]` has no effect on the register contents.
- R7: A change of `lane_sel` or `dir_rev` does not rearrange the existing contents. The new setting governs only the shifts at the following edges.
- R8: At a rising edge with `latch_hold`=0, the latch takes the register contents as they stood just before that edge. With `latch_hold`=1, the latch keeps its value.
- R9: With `blank_n`=0, every column output is 0.
- R10: With `blank_n`=1 and `pass_en`=0, every column output is 1.
- R11: With `blank_n`=1 and `pass_en`=1, column i (bit i-1 of `col`) shows latch bit i-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; all sampling is on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_sel | input | 1 | 0: six lanes of 16 stages; 1: three lanes of 32 stages |
| dir_rev | input | 1 | 0: shift toward high columns; 1: shift toward low columns |
| din | input | 6 | Pixel bus; bit k-1 is data line k |
| latch_hold | input | 1 | 0: latch loads on the edge; 1: latch holds |
| blank_n | input | 1 | 0 forces every column low |
| pass_en | input | 1 | 0 forces every column high when not blanked |
| col | output | 96 | Column outputs; bit i-1 is column i |

## Verification
A bus value reaches the register at the edge that samples it, and reaches the latch one edge later if hold is low. A bit sampled at edge 1 therefore appears on `col` only after edge 2, and it reaches its final lane stage on `col` after edge 17 (six lanes) or edge 33 (three lanes). The override inputs act on `col` with no clock at all. The bench drives every input on the falling edge and samples `col` one nanosecond after the rising edge. Every expected value is worked out with this extra latch edge already counted.

// File: rtl/col_pkg.sv
package col_pkg;

    // Decoded shift behaviour; encoding is {lane_sel, dir_rev}
    typedef enum logic [1:0] {
        SM_WIDE_FWD   = 2'b00,
        SM_WIDE_REV   = 2'b01,
        SM_NARROW_FWD = 2'b10,
        SM_NARROW_REV = 2'b11
    } shift_mode_e;

    // Column drive selection, highest priority first
    typedef enum logic [1:0] {
        DRV_LOW  = 2'b00,
        DRV_HIGH = 2'b01,
        DRV_DATA = 2'b10
    } drive_e;

endpackage

// File: rtl/col_shift_reg.sv
module col_shift_reg
    import col_pkg::*;
#(
    parameter int COLS   = 96,
    parameter int WIDE   = 6,
    parameter int NARROW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  shift_mode_e       mode,
    input  logic [WIDE-1:0]   din,
    output logic [COLS-1:0]   q
);
    localparam int WTOP = COLS - WIDE;
    localparam int NTOP = COLS - NARROW;

    logic [COLS-1:0] nxt;

    // Each bit picks one of four candidate sources, indexed by the mode code
    for (genvar i = 0; i < COLS; i++) begin : g_bit
        logic [3:0] cand;

        if (i < WIDE) begin : g_wf_in
            assign cand[SM_WIDE_FWD] = din[i];
        end else begin : g_wf_sh
            assign cand[SM_WIDE_FWD] = q[i-WIDE];
        end

        if (i >= WTOP) begin : g_wr_in
            assign cand[SM_WIDE_REV] = din[i-WTOP];
        end else begin : g_wr_sh
            assign cand[SM_WIDE_REV] = q[i+WIDE];
        end

        if (i < NARROW) begin : g_nf_in
            assign cand[SM_NARROW_FWD] = din[i];
        end else begin : g_nf_sh
            assign cand[SM_NARROW_FWD] = q[i-NARROW];
        end

        if (i >= NTOP) begin : g_nr_in
            assign cand[SM_NARROW_REV] = din[i-NTOP];
        end else begin : g_nr_sh
            assign cand[SM_NARROW_REV] = q[i+NARROW];
        end

        assign nxt[i] = cand[mode];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    AST_WIDE_FWD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mode == SM_WIDE_FWD |=> (q[COLS-1:WIDE] == $past(q[WTOP-1:0])) && (q[WIDE-1:0] == $past(din))); // R2
    AST_WIDE_REV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mode == SM_WIDE_REV |=> (q[WTOP-1:0] == $past(q[COLS-1:WIDE])) && (q[COLS-1:WTOP] == $past(din))); // R3
    AST_NARROW_FWD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mode == SM_NARROW_FWD |=> (q[COLS-1:NARROW] == $past(q[NTOP-1:0])) && (q[NARROW-1:0] == $past(din[NARROW-1:0]))); // R4
    AST_NARROW_REV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mode == SM_NARROW_REV |=> (q[NTOP-1:0] == $past(q[COLS-1:NARROW])) && (q[COLS-1:NTOP] == $past(din[NARROW-1:0]))); // R5

endmodule

// File: rtl/col_hold_latch.sv
module col_hold_latch #(
    parameter int COLS = 96
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic [COLS-1:0] d,
    output logic [COLS-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (!hold) q <= d;
    end

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(q)); // R8
    AST_LATCH_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> q == $past(d)); // R8

endmodule

// File: rtl/col_out_ctl.sv
module col_out_ctl
    import col_pkg::*;
#(
    parameter int COLS = 96
) (
    input  logic            blank_n,
    input  logic            pass_en,
    input  logic [COLS-1:0] held,
    output logic [COLS-1:0] col
);
    drive_e drv;

    always_comb begin
        if (!blank_n)      drv = DRV_LOW;
        else if (!pass_en) drv = DRV_HIGH;
        else               drv = DRV_DATA;
    end

    always_comb begin
        unique case (drv)
            DRV_LOW:  col = '0;
            DRV_HIGH: col = '1;
            DRV_DATA: col = held;
            default:  col = '0;
        endcase
    end

endmodule

// File: rtl/col_loader.sv
module col_loader
    import col_pkg::*;
#(
    parameter int COLS   = 96,
    parameter int WIDE   = 6,
    parameter int NARROW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lane_sel,
    input  logic            dir_rev,
    input  logic [WIDE-1:0] din,
    input  logic            latch_hold,
    input  logic            blank_n,
    input  logic            pass_en,
    output logic [COLS-1:0] col
);
    shift_mode_e     mode;
    logic [COLS-1:0] sr_q;
    logic [COLS-1:0] held_q;

    assign mode = shift_mode_e'({lane_sel, dir_rev});

    col_shift_reg #(.COLS(COLS), .WIDE(WIDE), .NARROW(NARROW)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .din   (din),
        .q     (sr_q)
    );

    col_hold_latch #(.COLS(COLS)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (latch_hold),
        .d     (sr_q),
        .q     (held_q)
    );

    col_out_ctl #(.COLS(COLS)) u_out (
        .blank_n (blank_n),
        .pass_en (pass_en),
        .held    (held_q),
        .col     (col)
    );

    AST_BLANK_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |-> col == '0); // R9
    AST_FORCE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && !pass_en) |-> &col); // R10
    AST_PASS_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && pass_en) |-> col == held_q); // R11
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |-> (sr_q == '0) && (held_q == '0)); // R1

endmodule

// File: tb/col_loader_tb.sv
module col_loader_tb_top;
    localparam int CLK_HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lane_sel = 1'b0, dir_rev = 1'b0;
    logic [5:0]  din = '0;
    logic        latch_hold = 1'b0, blank_n = 1'b1, pass_en = 1'b1;
    logic [95:0] col;

    int n_chk = 0;
    int n_bad = 0;
    logic [95:0] m_sr, m_lt;

    always #CLK_HALF clk = ~clk;

    col_loader dut_i (
        .clk(clk), .rst_n(rst_n), .lane_sel(lane_sel), .dir_rev(dir_rev),
        .din(din), .latch_hold(latch_hold), .blank_n(blank_n),
        .pass_en(pass_en), .col(col)
    );

    // {lane_sel, dir_rev, din[5:0], latch_hold, blank_n, pass_en}
    localparam logic [10:0] VEC [16] = '{
        11'b00_101101_011, 11'b00_010010_011, 11'b00_111111_111, 11'b00_000111_011,
        11'b01_110001_011, 11'b01_001110_001, 11'b01_101010_101, 11'b10_111011_011,
        11'b10_000101_011, 11'b10_111000_111, 11'b11_010011_011, 11'b11_101100_011,
        11'b11_000001_010, 11'b00_100100_011, 11'b10_011010_011, 11'b01_111111_011
    };

    task automatic check(input string tag, input logic [95:0] got, input logic [95:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [95:0] model_out(input logic bk, input logic en);
        if (!bk) return '0;
        if (!en) return '1;
        return m_lt;
    endfunction

    // Drive on falling edge, let one rising edge pass, update the reference
    task automatic step(input logic ns, input logic rv, input logic [5:0] d,
                        input logic sb, input logic bk, input logic en);
        logic [95:0] old_sr;
        int stride;
        @(negedge clk);
        lane_sel = ns; dir_rev = rv; din = d; latch_hold = sb; blank_n = bk; pass_en = en;
        @(posedge clk);
        #1;
        old_sr = m_sr;
        stride = ns ? 3 : 6;
        if (!sb) m_lt = old_sr;
        if (!rv) begin
            for (int j = 0; j < 96; j++)
                m_sr[j] = (j < stride) ? d[j] : old_sr[j-stride];
        end else begin
            for (int j = 0; j < 96; j++)
                m_sr[j] = (j >= 96 - stride) ? d[j-(96-stride)] : old_sr[j+stride];
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        m_sr = '0; m_lt = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle_steps(input int n, input logic ns, input logic rv);
        for (int k = 0; k < n; k++) step(ns, rv, 6'b0, 1'b0, 1'b1, 1'b1);
    endtask

    initial begin
        #(CLK_HALF * 2 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_sr = '0; m_lt = '0;
        #5;
        check("R1 reset state", col, 96'b0);
        rst_n = 1'b1;

        // R2: six lanes forward
        do_reset();
        step(1'b0, 1'b0, 6'b000001, 1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 6'b0, 1'b0, 1'b1, 1'b1);
        check("R2 entry at column 1", col, 96'b1);
        idle_steps(15, 1'b0, 1'b0);
        check("R2 column 91 after 16 edges", col, 96'b1 << 90);

        // R3: six lanes reverse
        do_reset();
        step(1'b0, 1'b1, 6'b100000, 1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 6'b0, 1'b0, 1'b1, 1'b1);
        check("R3 entry at column 96", col, 96'b1 << 95);
        idle_steps(15, 1'b0, 1'b1);
        check("R3 column 6 after 16 edges", col, 96'b1 << 5);

        // R4: three lanes forward
        do_reset();
        step(1'b1, 1'b0, 6'b000100, 1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b0, 6'b0, 1'b0, 1'b1, 1'b1);
        check("R4 entry at column 3", col, 96'b1 << 2);
        idle_steps(31, 1'b1, 1'b0);
        check("R4 column 96 after 32 edges", col, 96'b1 << 95);

        // R5: three lanes reverse
        do_reset();
        step(1'b1, 1'b1, 6'b000001, 1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b1, 6'b0, 1'b0, 1'b1, 1'b1);
        check("R5 entry at column 94", col, 96'b1 << 93);
        idle_steps(31, 1'b1, 1'b1);
        check("R5 column 1 after 32 edges", col, 96'b1);

        // R6: upper data lines ignored in three-lane mode
        do_reset();
        for (int k = 0; k < 33; k++) step(1'b1, k[0], 6'b111000, 1'b0, 1'b1, 1'b1);
        check("R6 lines 4-6 ignored", col, 96'b0);

        // R7: mode change does not rearrange contents
        do_reset();
        step(1'b0, 1'b0, 6'b000001, 1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 6'b0, 1'b0, 1'b1, 1'b1);
        check("R7 contents kept across change", col, 96'b1);
        step(1'b0, 1'b1, 6'b0, 1'b0, 1'b1, 1'b1);
        check("R7 new direction applies", col, 96'b0);

        // R8: hold and copy
        do_reset();
        step(1'b0, 1'b0, 6'b111111, 1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 6'b0, 1'b1, 1'b1, 1'b1);
        check("R8 latch held", col, 96'b0);
        step(1'b0, 1'b0, 6'b0, 1'b0, 1'b1, 1'b1);
        check("R8 latch copies pre-edge contents", col, 96'hFC0);

        // R9, R10, R11: overrides on nonzero latch
        step(1'b0, 1'b0, 6'b0, 1'b1, 1'b0, 1'b1);
        check("R9 blank forces low", col, 96'b0);
        step(1'b0, 1'b0, 6'b0, 1'b1, 1'b0, 1'b0);
        check("R9 blank wins over force high", col, 96'b0);
        step(1'b0, 1'b0, 6'b0, 1'b1, 1'b1, 1'b0);
        check("R10 force high", col, '1);
        step(1'b0, 1'b0, 6'b0, 1'b1, 1'b1, 1'b1);
        check("R11 latched data shown", col, 96'hFC0);

        // Table walk against the reference model
        do_reset();
        for (int r = 0; r < 3; r++) begin
            for (int v = 0; v < 16; v++) begin
                step(VEC[v][10], VEC[v][9], VEC[v][8:3], VEC[v][2], VEC[v][1], VEC[v][0]);
                check("R11 table vector", col, model_out(VEC[v][1], VEC[v][0]));
            end
        end

        // R1: asynchronous reset mid-run
        step(1'b0, 1'b0, 6'b111111, 1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 6'b111111, 1'b0, 1'b1, 1'b1);
        #1 rst_n = 1'b0;
        #1 check("R1 async reset clears", col, 96'b0);
        @(negedge clk) rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule